// File: doc/BRIEF.md
# Program Counter and Flow-Control Unit

This block holds the program counter of a word-addressed microcontroller core and works out where execution goes next. It takes one instruction at a time, already decoded: an operation code, a signed word offset, an absolute target, a 16-bit indirect pointer with an 8-bit extension byte, the status register with a bit selector and polarity, a skip-condition result and a flag saying whether the following instruction is two words long. For every instruction it reports how many core cycles that instruction costs.

Calls save a 16-bit return address on a byte-wide data stack, and returns restore it. Both go through a simple memory port that carries one byte per clock and returns read data one clock after the request. The stack pointer is kept inside the block. Instructions that touch the stack hold `busy` high until they finish. Every instruction ends with a one-cycle `done` pulse, after which `pc`, `sp` and `cycles` show the result.

Top module: `flow_ctl`

## Requirements
- R1: After reset, `pc` is 0, `sp` is `SP_RESET` (0x0080 by default), and `busy`, `done` and `iflag_set` are low.
- R2: Op 0 (plain one-word instruction) sets `pc` to pc+1 and reports 1 cycle, with `done` high in the cycle after `start` is accepted.
- R3: Op 1 (branch) tests `sreg[sbit]` against `sval`. On a match it jumps to pc+1+`koff` (signed, wrapping modulo 2^PCW) and reports 2 cycles. Otherwise it goes to pc+1 and reports 1 cycle.
- R4: Op 2 (skip) goes to pc+1 in 1 cycle when `skip_hit` is low. When `skip_hit` is high it goes to pc+2 in 2 cycles, or to pc+3 in 3 cycles if `next_long` is high.
- R5: Op 3 (absolute jump) loads `tgt` and reports 3 cycles. Op 4 (relative jump) goes to pc+1+`koff` and reports 2 cycles.
- R6: Op 5 (indirect jump) loads the zero-extended `zptr`. Op 6 (extended indirect jump) loads {`zext`,`zptr`}. Both report 2 cycles; for example `zext`=1 and `zptr`=0x1040 give 0x11040.
- R7: The calls have these targets, return addresses and cycle counts: op 7 goes to `tgt`, saves pc+2, 5 cycles; op 8 goes to pc+1+`koff`, saves pc+1, 4 cycles; op 9 goes to `zptr`, saves pc+1, 3 cycles; op 10 goes to {`zext`,`zptr`}, saves pc+1, 4 cycles.
- R8: A call writes the low 16 bits of the return address as two bytes, low byte at address `sp` and then high byte at `sp`-1, and then lowers `sp` by 2. A call at pc 0 with `sp`=0x80 leaves 1 at 0x80 and `sp` at 0x7E.
- R9: Op 11 (return) reads the high byte at `sp`+1 and the low byte at `sp`+2, loads `pc` with that value zero-extended, raises `sp` by 2 and reports 5 cycles.
- R10: Op 12 (interrupt return) behaves as op 11 and also pulses `iflag_set` in the same cycle as `done`. No other op raises `iflag_set`.
- R11: While `busy` is high, `start` is ignored. The running instruction completes unchanged, and no extra `done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the presented instruction when idle |
| op | input | 4 | Decoded operation code |
| sbit | input | 3 | Status bit index for a branch |
| sval | input | 1 | Branch when the selected bit equals this |
| sreg | input | 8 | Current status register |
| koff | input | KW | Signed word offset |
| tgt | input | PCW | Absolute target |
| zptr | input | 16 | Indirect pointer |
| zext | input | 8 | Extension byte for extended indirect forms |
| skip_hit | input | 1 | Skip condition is true |
| next_long | input | 1 | Following instruction is two words long |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write byte |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe; data one cycle later |
| mem_rdata | input | 8 | Stack read byte |
| pc | output | PCW | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | Instruction completed this cycle |
| cycles | output | 3 | Cycle count of the last instruction |
| iflag_set | output | 1 | Set the interrupt-enable flag |

## Verification
The hardest case to reach is the one where the return path and the stack interact. A return must restore an address that an earlier call wrote, after nested calls and returns have moved the stack pointer around. An extended indirect call must also lose its upper address bits on the way back. To produce this, the stimulus runs a nested chain of absolute, relative and extended calls, then unwinds it with interrupt and plain returns. A reference queue of return addresses predicts every popped value. A second hard case is a competing `start` raised in the middle of a push. It is reached by driving a jump one cycle after a call is accepted.

// File: rtl/flow_ctl.sv
module flow_ctl #(
  parameter int PCW = 22,
  parameter int KW = 12,
  parameter logic [15:0] SP_RESET = 16'h0080
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     op,
  input  logic [2:0]     sbit,
  input  logic           sval,
  input  logic [7:0]     sreg,
  input  logic [KW-1:0]  koff,
  input  logic [PCW-1:0] tgt,
  input  logic [15:0]    zptr,
  input  logic [7:0]     zext,
  input  logic           skip_hit,
  input  logic           next_long,
  output logic [15:0]    mem_addr,
  output logic [7:0]     mem_wdata,
  output logic           mem_we,
  output logic           mem_re,
  input  logic [7:0]     mem_rdata,
  output logic [PCW-1:0] pc,
  output logic [15:0]    sp,
  output logic           busy,
  output logic           done,
  output logic [2:0]     cycles,
  output logic           iflag_set
);
  localparam logic [3:0] OP_STEP = 4'd0, OP_BR = 4'd1, OP_SKIP = 4'd2, OP_JMP = 4'd3,
                         OP_RJMP = 4'd4, OP_IJMP = 4'd5, OP_EIJMP = 4'd6, OP_CALL = 4'd7,
                         OP_RCALL = 4'd8, OP_ICALL = 4'd9, OP_EICALL = 4'd10,
                         OP_RET = 4'd11, OP_RETI = 4'd12;

  typedef enum logic [2:0] {S_IDLE, S_PUSH0, S_PUSH1, S_POP0, S_POP1, S_POP2} st_t;
  st_t st;

  logic [PCW-1:0] tgt_q;
  logic [15:0]    ret_q;
  logic [7:0]     hi_q;
  logic           reti_q;

  wire [PCW-1:0] pc1  = pc + PCW'(1);
  wire [PCW-1:0] kext = {{(PCW-KW){koff[KW-1]}}, koff};
  wire [PCW-1:0] rel  = pc1 + kext;
  wire [PCW-1:0] zt   = {{(PCW-16){1'b0}}, zptr};
  wire [23:0]    ez   = {zext, zptr};
  wire [PCW-1:0] ezt  = ez[PCW-1:0];
  wire           hit  = sreg[sbit] == sval;
  wire           is_push = op inside {OP_CALL, OP_RCALL, OP_ICALL, OP_EICALL};
  wire           is_pop  = op inside {OP_RET, OP_RETI};

  logic [PCW-1:0] nxt, ret_n;
  logic [2:0]     ncyc;

  always_comb begin
    nxt = pc1;
    ret_n = pc1;
    ncyc = 3'd1;
    case (op)
      OP_BR:     if (hit) begin nxt = rel; ncyc = 3'd2; end
      OP_SKIP:   if (skip_hit) begin
                   nxt  = next_long ? pc + PCW'(3) : pc + PCW'(2);
                   ncyc = next_long ? 3'd3 : 3'd2;
                 end
      OP_JMP:    begin nxt = tgt; ncyc = 3'd3; end
      OP_RJMP:   begin nxt = rel; ncyc = 3'd2; end
      OP_IJMP:   begin nxt = zt;  ncyc = 3'd2; end
      OP_EIJMP:  begin nxt = ezt; ncyc = 3'd2; end
      OP_CALL:   begin nxt = tgt; ncyc = 3'd5; ret_n = pc + PCW'(2); end
      OP_RCALL:  begin nxt = rel; ncyc = 3'd4; end
      OP_ICALL:  begin nxt = zt;  ncyc = 3'd3; end
      OP_EICALL: begin nxt = ezt; ncyc = 3'd4; end
      OP_RET, OP_RETI: ncyc = 3'd5;
      default: ;
    endcase
  end

  assign busy      = st != S_IDLE;
  assign mem_we    = st == S_PUSH0 || st == S_PUSH1;
  assign mem_re    = st == S_POP0 || st == S_POP1;
  assign mem_wdata = st == S_PUSH1 ? ret_q[15:8] : ret_q[7:0];

  always_comb begin
    case (st)
      S_PUSH1: mem_addr = sp - 16'd1;
      S_POP0:  mem_addr = sp + 16'd1;
      S_POP1:  mem_addr = sp + 16'd2;
      default: mem_addr = sp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= '0;
      sp <= SP_RESET;
      cycles <= '0;
      done <= 1'b0;
      iflag_set <= 1'b0;
      tgt_q <= '0;
      ret_q <= '0;
      hi_q <= '0;
      reti_q <= 1'b0;
    end else begin
      done <= 1'b0;
      iflag_set <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cycles <= ncyc;
          if (is_push) begin
            ret_q <= ret_n[15:0];
            tgt_q <= nxt;
            st <= S_PUSH0;
          end else if (is_pop) begin
            reti_q <= op == OP_RETI;
            st <= S_POP0;
          end else begin
            pc <= nxt;
            done <= 1'b1;
          end
        end
        S_PUSH0: st <= S_PUSH1;
        S_PUSH1: begin
          sp <= sp - 16'd2;
          pc <= tgt_q;
          done <= 1'b1;
          st <= S_IDLE;
        end
        S_POP0: st <= S_POP1;
        S_POP1: begin
          hi_q <= mem_rdata;
          st <= S_POP2;
        end
        S_POP2: begin
          pc <= {{(PCW-16){1'b0}}, hi_q, mem_rdata};
          sp <= sp + 16'd2;
          done <= 1'b1;
          iflag_set <= reti_q;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
  parameter int PCW = 22
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           mem_we,
  input logic           mem_re,
  input logic [15:0]    sp,
  input logic [PCW-1:0] pc,
  input logic [2:0]     cycles,
  input logic           iflag_set
);
  p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_port_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);
  p_push_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_we)) |-> sp == $past(sp) - 16'd2);
  p_pop_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_re, 2)) |-> sp == $past(sp) + 16'd2);
  p_sp_moves_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> done);
  p_pc_moves_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> done);
  p_iflag_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iflag_set |-> done);
  p_cycle_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= 3'd1 && cycles <= 3'd5));
endmodule

bind flow_ctl flow_ctl_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_re(mem_re), .sp(sp), .pc(pc), .cycles(cycles), .iflag_set(iflag_set)
);

// File: tb/sim_flow_ctl.sv
module sim_flow_ctl;
  localparam int PCW = 22;
  localparam int KW = 12;
  localparam int MASK = (1 << PCW) - 1;

  logic clk = 0, rst_n = 0, start = 0, sval = 0, skip_hit = 0, next_long = 0;
  logic [3:0] op = 0;
  logic [2:0] sbit = 0;
  logic [7:0] sreg = 0, zext = 0, mem_rdata = 0, mem_wdata;
  logic [KW-1:0] koff = 0;
  logic [PCW-1:0] tgt = 0, pc;
  logic [15:0] zptr = 0, mem_addr, sp;
  logic mem_we, mem_re, busy, done, iflag_set;
  logic [2:0] cycles;

  always #10 clk = ~clk;

  flow_ctl #(.PCW(PCW), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sbit(sbit), .sval(sval),
    .sreg(sreg), .koff(koff), .tgt(tgt), .zptr(zptr), .zext(zext),
    .skip_hit(skip_hit), .next_long(next_long), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .busy(busy), .done(done), .cycles(cycles), .iflag_set(iflag_set)
  );

  logic [7:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  end
  function automatic int rd(int a);
    return ram.exists(a) ? int'(ram[a]) : 0;
  endfunction

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  int exp_pc = 0, exp_sp = 'h80;
  int rq[$];
  int p_op, p_k, p_t, p_z, p_e, p_sb, p_sv, p_sr;
  bit p_sh, p_nl;
  string p_tag = "R1";

  always @(negedge clk) if (rst_n && !finished) begin
    if (done) begin
      int npc, nc, r;
      npc = exp_pc + 1; nc = 1;
      case (p_op)
        1: if (((p_sr >> p_sb) & 1) == p_sv) begin npc = exp_pc + 1 + p_k; nc = 2; end
        2: if (p_sh) begin npc = exp_pc + (p_nl ? 3 : 2); nc = p_nl ? 3 : 2; end
        3: begin npc = p_t; nc = 3; end
        4: begin npc = exp_pc + 1 + p_k; nc = 2; end
        5: begin npc = p_z; nc = 2; end
        6: begin npc = (p_e << 16) | p_z; nc = 2; end
        7: begin npc = p_t; nc = 5; end
        8: begin npc = exp_pc + 1 + p_k; nc = 4; end
        9: begin npc = p_z; nc = 3; end
        10: begin npc = (p_e << 16) | p_z; nc = 4; end
        11, 12: begin npc = rq.pop_back(); nc = 5; exp_sp = (exp_sp + 2) & 'hffff; end
        default: ;
      endcase
      if (p_op >= 7 && p_op <= 10) begin
        r = ((p_op == 7) ? exp_pc + 2 : exp_pc + 1) & 'hffff;
        check("R8 low byte", rd(exp_sp), r & 'hff);
        check("R8 high byte", rd((exp_sp - 1) & 'hffff), r >> 8);
        rq.push_back(r);
        exp_sp = (exp_sp - 2) & 'hffff;
      end
      check({p_tag, " cycles"}, int'(cycles), nc);
      exp_pc = npc & MASK;
    end
    check({p_tag, " pc"}, int'(pc), exp_pc);
    check({p_tag, " sp"}, int'(sp), exp_sp);
    check("R10 iflag_set", int'(iflag_set), (done && p_op == 12) ? 1 : 0);
  end

  task automatic issue(string tag, int o, int k = 0, int t = 0, int z = 0, int e = 0,
                       int sb = 0, int sv = 0, int sr = 0, bit sh = 0, bit nl = 0);
    @(negedge clk);
    p_tag = tag; p_op = o; p_k = k; p_t = t; p_z = z; p_e = e;
    p_sb = sb; p_sv = sv; p_sr = sr; p_sh = sh; p_nl = nl;
    op = o[3:0]; koff = k[KW-1:0]; tgt = t[PCW-1:0]; zptr = z[15:0]; zext = e[7:0];
    sbit = sb[2:0]; sval = sv[0]; sreg = sr[7:0]; skip_hit = sh; next_long = nl;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc", int'(pc), 0);
    check("R1 sp", int'(sp), 'h80);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 iflag_set", int'(iflag_set), 0);
    rst_n = 1;

    issue("R2", 0);
    issue("R3", 1, -2, 0, 0, 0, 3, 1, 'h08);
    check("R3 backward branch", int'(pc), 0);
    issue("R3", 1, 4, 0, 0, 0, 0, 0, 'h01);
    issue("R3", 1, 4, 0, 0, 0, 0, 0, 'h08);
    issue("R3", 1, 7, 0, 0, 0, 7, 1, 'h7f);
    issue("R5", 3, 0, 'h5c);
    check("R5 absolute", int'(pc), 'h5c);
    issue("R5", 4, 2);
    issue("R4", 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R4", 2, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    issue("R4", 2, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    check("R4 long skip", int'(pc), 'h65);
    issue("R6", 5, 0, 0, 'h1040);
    issue("R6", 6, 0, 0, 'h1040, 1);
    check("R6 extended", int'(pc), 'h11040);

    issue("R5", 3, 0, 0);
    issue("R7", 9, 0, 0, 'h2020);
    check("R8 stored return", rd('h80), 1);
    check("R8 sp after call", int'(sp), 'h7e);
    issue("R9", 11);
    check("R9 returned", int'(pc), 1);

    issue("R7", 7, 0, 'h5c);
    issue("R7", 8, -4);
    issue("R7", 10, 0, 0, 'h1234, 1);
    check("R7 extended call", int'(pc), 'h11234);
    issue("R10", 12);
    issue("R9", 11);
    issue("R9", 11);
    check("R9 unwound", int'(pc), 3);

    // R11: a jump offered while a call is pushing must be dropped
    @(negedge clk);
    p_tag = "R11"; p_op = 7; p_t = 'h100;
    op = 4'd7; tgt = 'h100; start = 1;
    @(negedge clk);
    check("R11 busy", int'(busy), 1);
    op = 4'd3; tgt = 'h333;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 no extra done", int'(done), 0);
    check("R11 target kept", int'(pc), 'h100);
    issue("R9", 11);

    issue("R5", 3, 0, 0);
    issue("R5", 4, -1);
    issue("R3", 1, -3, 0, 0, 0, 7, 0, 0);
    check("R3 wrap", int'(pc), MASK - 1);
    issue("R2", 0);
    repeat (2) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule